// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block decides whether a received frame addressed to a given BSSID should be taken in, and therefore acknowledged, by the station. It holds the station's own 48-bit MAC address and a 48-bit comparison mask. Both are written and read back through a small word-wide register port with byte enables. For each BSSID offered with a valid strobe, the block returns an accept flag together with a done strobe one clock later.

The mask lets a single address comparator serve several virtual networks at once. Software clears the mask bits on which the served BSSIDs differ from the station address. Only the remaining bits are compared. The price is that a foreign BSSID which happens to agree on the compared bits is also accepted. That behaviour is intended and is not suppressed.

The upper address word shares its register with a 16-bit control field that other logic owns. Byte enables keep address writes from disturbing that field.

Top module: `bssid_filter`

## Requirements
- R1: A compare accepts exactly when every bit set in the mask has the same value in the offered BSSID and in the station MAC. Bits whose mask bit is clear are not compared.
- R2: `accept_valid` is high in the clock cycle that follows a cycle with `frame_valid` high, and low in every other cycle. `accept` is low whenever `accept_valid` is low.
- R3: Register index 0 holds MAC bits 31:0, with address byte 0 in bits 7:0. The BSSID input uses the same packing, so MAC bit n is compared with `frame_bssid` bit n.
- R4: Register index 1 holds MAC bits 47:32 in its bits 15:0 and a 16-bit control field in its bits 31:16. A write changes only the bytes whose `reg_wstrb` bit is set, so a write with strobe 4'b0011 leaves the control field unchanged.
- R5: Register index 2 holds mask bits 31:0, and register index 3 holds mask bits 47:32 in its bits 15:0. Bits 31:16 of index 3 always read as zero, and writes to them are ignored.
- R6: After reset, the mask is all ones, the MAC and the control field are zero, and `accept_valid` is low.
- R7: With an all-ones mask, only a BSSID equal to the MAC is accepted. Clearing one mask bit makes a BSSID that differs from the MAC only in that bit accepted.
- R8: A BSSID outside the served set that agrees with the MAC on all masked bits is accepted.
- R9: A register write in the same cycle as a compare does not affect that compare. It applies from the next compare onward.
- R10: `reg_rdata` shows, in the same cycle, the current contents of the register selected by `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register index (0 MAC low, 1 MAC high/control, 2 mask low, 3 mask high) |
| reg_wstrb | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| frame_valid | input | 1 | Compare request strobe |
| frame_bssid | input | 48 | BSSID of the received frame |
| accept_valid | output | 1 | Decision strobe, one cycle after the request |
| accept | output | 1 | Frame accepted |

## Verification
The case that is hardest to reach from the ports is a register write that lands in the same clock edge as a compare. If the design is wrong, the new mask leaks into the decision already being made. The bench drives a mask write and a compare request in the same cycle, using a BSSID that only the new mask would accept. It then checks that this compare rejects and that the next compare accepts. A second delicate case is a partial-strobe write to the shared address/control word. The bench first fills the control field, then rewrites only the address bytes and reads the whole word back.

// File: rtl/bssflt_pkg.sv
package bssflt_pkg;

    localparam int ADDR_W  = 48;
    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int HI_W    = ADDR_W - WORD_W;
    localparam int CTRL_W  = WORD_W - HI_W;

    typedef enum logic [1:0] {
        RIX_MAC_LO  = 2'd0,
        RIX_MAC_HI  = 2'd1,
        RIX_MASK_LO = 2'd2,
        RIX_MASK_HI = 2'd3
    } reg_index_e;

    typedef struct packed {
        logic [ADDR_W-1:0] mac;
        logic [ADDR_W-1:0] mask;
    } match_cfg_t;

    localparam logic [WORD_W-1:0] HI_FIELD_MASK = {{CTRL_W{1'b0}}, {HI_W{1'b1}}};

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BYTES-1:0]  strb
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int b = 0; b < BYTES; b++) begin
            if (strb[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

    function automatic logic masked_equal(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] b,
        input logic [ADDR_W-1:0] m
    );
        return ((a ^ b) & m) == '0;
    endfunction

endpackage

// File: rtl/bssflt_regfile.sv
module bssflt_regfile
    import bssflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTES-1:0]  wstrb,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output match_cfg_t        cfg
);

    logic [WORD_W-1:0] mac_lo_q, mac_hi_q, mask_lo_q, mask_hi_q;
    logic [WORD_W-1:0] mask_hi_next;
    reg_index_e        sel;

    assign sel          = reg_index_e'(addr);
    assign mask_hi_next = merge_bytes(mask_hi_q, wdata, wstrb) & HI_FIELD_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_lo_q  <= '0;
            mac_hi_q  <= '0;
            mask_lo_q <= '1;
            mask_hi_q <= HI_FIELD_MASK;
        end else if (wr_en) begin
            case (sel)
                RIX_MAC_LO:  mac_lo_q  <= merge_bytes(mac_lo_q, wdata, wstrb);
                RIX_MAC_HI:  mac_hi_q  <= merge_bytes(mac_hi_q, wdata, wstrb);
                RIX_MASK_LO: mask_lo_q <= merge_bytes(mask_lo_q, wdata, wstrb);
                RIX_MASK_HI: mask_hi_q <= mask_hi_next;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            RIX_MAC_LO:  rdata = mac_lo_q;
            RIX_MAC_HI:  rdata = mac_hi_q;
            RIX_MASK_LO: rdata = mask_lo_q;
            default:     rdata = mask_hi_q;
        endcase
    end

    assign cfg.mac  = {mac_hi_q[HI_W-1:0], mac_lo_q};
    assign cfg.mask = {mask_hi_q[HI_W-1:0], mask_lo_q};

    // R4: address-only write keeps the control field
    assert_ctrl_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RIX_MAC_HI && wstrb[BYTES-1:BYTES/2] == '0)
        |=> $stable(mac_hi_q[WORD_W-1:HI_W]));

    // R5: upper half of the mask-high word never holds ones
    assert_mask_hi_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (sel == RIX_MASK_HI) |-> (rdata[WORD_W-1:HI_W] == '0));

    // R6: reset state
    assert_reset_state_R6: assert property (@(posedge clk)
        $past(rst) |-> (cfg.mask == '1 && cfg.mac == '0));

endmodule

// File: rtl/bssflt_match.sv
module bssflt_match
    import bssflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  match_cfg_t        cfg,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_bssid,
    output logic              done,
    output logic              hit
);

    logic done_q, hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            done_q <= req_valid;
            hit_q  <= req_valid && masked_equal(req_bssid, cfg.mac, cfg.mask);
        end
    end

    assign done = done_q;
    assign hit  = hit_q;

    // R2: done strobe tracks the request one cycle later
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!done && !hit));

    // R7: with an all-ones mask only the exact address is accepted
    assert_exact_match_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg.mask == '1 && req_bssid != cfg.mac) |=> !hit);

endmodule

// File: rtl/bssid_filter.sv
module bssid_filter
    import bssflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [3:0]        reg_wstrb,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_valid,
    input  logic [47:0]       frame_bssid,
    output logic              accept_valid,
    output logic              accept
);

    match_cfg_t cfg;

    bssflt_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wstrb (reg_wstrb),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    bssflt_match u_match (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .req_valid (frame_valid),
        .req_bssid (frame_bssid),
        .done      (accept_valid),
        .hit       (accept)
    );

endmodule

// File: tb/bssid_filter_tb.sv
module bssid_filter_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [3:0]  reg_wstrb;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        frame_valid;
    logic [47:0] frame_bssid;
    logic        accept_valid;
    logic        accept;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bssid_filter u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_valid(frame_valid), .frame_bssid(frame_bssid),
        .accept_valid(accept_valid), .accept(accept)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wstrb = '0;
    endtask

    task automatic reg_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic compare(input string req, input logic [47:0] b, input logic exp);
        @(negedge clk);
        frame_valid = 1'b1; frame_bssid = b;
        @(negedge clk);
        frame_valid = 1'b0;
        check({req, " valid"}, {47'h0, accept_valid}, 48'h1);
        check({req, " accept"}, {47'h0, accept}, {47'h0, exp});
        @(negedge clk);
        check("R2 strobe drops", {47'h0, accept_valid}, 48'h0);
    endtask

    task automatic t_reset;
        check("R6 accept_valid", {47'h0, accept_valid}, 48'h0);
        reg_check("R6 mac lo", 2'd0, 32'h0);
        reg_check("R6 mac hi/ctrl", 2'd1, 32'h0);
        reg_check("R6 mask lo", 2'd2, 32'hFFFF_FFFF);
        reg_check("R6 mask hi", 2'd3, 32'h0000_FFFF);
    endtask

    task automatic t_same_cycle_write;
        // mac zero, mask all ones: 0x5 rejected on this compare even though the new mask
        // written in the same cycle would accept it (R9)
        @(negedge clk);
        frame_valid = 1'b1; frame_bssid = 48'h5;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wstrb = 4'hF; reg_wdata = 32'h0;
        @(negedge clk);
        frame_valid = 1'b0; reg_wr = 1'b0; reg_wstrb = '0;
        check("R9 same-cycle compare", {47'h0, accept}, 48'h0);
        compare("R9 next compare", 48'h5, 1'b1);
        reg_write(2'd2, 4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic t_registers;
        reg_write(2'd1, 4'hF, 32'hABCD_1234);
        reg_check("R4 full write", 2'd1, 32'hABCD_1234);
        reg_write(2'd1, 4'h3, 32'h9999_5678);
        reg_check("R4 ctrl kept", 2'd1, 32'hABCD_5678);
        reg_write(2'd0, 4'h1, 32'h0000_00EE);
        reg_check("R10 byte write", 2'd0, 32'h0000_00EE);
        reg_write(2'd3, 4'hF, 32'hFFFF_1111);
        reg_check("R5 mask hi upper zero", 2'd3, 32'h0000_1111);
        reg_write(2'd3, 4'hF, 32'h0000_FFFF);
        reg_check("R5 mask hi restored", 2'd3, 32'h0000_FFFF);
    endtask

    task automatic t_byte_order;
        // MAC bytes 00:11:22:33:44:55, byte 0 in bits 7:0
        reg_write(2'd0, 4'hF, 32'h3322_1100);
        reg_write(2'd1, 4'h3, 32'h0000_5544);
        compare("R3 packed exact", 48'h5544_3322_1100, 1'b1);
        compare("R3 byte-swapped", 48'h0011_2233_4455, 1'b0);
        compare("R7 one bit off", 48'h5544_3322_1101, 1'b0);
        reg_write(2'd2, 4'hF, 32'hFFFF_FFFE);
        compare("R7 cleared bit ignored", 48'h5544_3322_1101, 1'b1);
        compare("R1 other bit still compared", 48'h5544_3322_1103, 1'b0);
        reg_write(2'd2, 4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic t_multi_bss;
        logic [47:0] mac, b1, b2, m;
        mac = 48'h0000_0000_0001; b1 = 48'h4; b2 = 48'h9;
        m = ~(mac ^ b1) & ~(mac ^ b2);
        reg_write(2'd0, 4'hF, mac[31:0]);
        reg_write(2'd1, 4'h3, {16'h0, mac[47:32]});
        reg_write(2'd2, 4'hF, m[31:0]);
        reg_write(2'd3, 4'h3, {16'h0, m[47:32]});
        compare("R1 own mac", mac, 1'b1);
        compare("R1 served bss 1", b1, 1'b1);
        compare("R1 served bss 2", b2, 1'b1);
        compare("R1 foreign rejected", 48'h6, 1'b0);
        compare("R8 foreign false accept", 48'hD, 1'b1);
        compare("R1 upper bits compared", 48'h0100_0000_0001, 1'b0);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wstrb = '0; reg_wdata = '0;
        frame_valid = 1'b0; frame_bssid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_same_cycle_write();
        t_registers();
        t_byte_order();
        t_multi_bss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule